// File: doc/BRIEF.md
# Erase Suspend and Resume Controller

This block sits next to one bank's sector-erase engine. It watches the command strobes written to the device. When a suspend command is addressed to its own bank while a sector erase is under way, it parks that erase. A matching resume command lets the erase continue from the progress count captured at the moment of suspension. While the erase is parked, the controller decides for every read address whether the bank answers with array data or with status. It also grants program requests that target sectors which are not queued for erasure.

The erase engine reports its phase on a two-bit state input. The phase is idle, the acceptance window in which further sectors may still be queued, active erasing, or chip erase. A suspend that lands in the acceptance window parks the erase on the next edge. A suspend that lands during active erasing raises the pause request at once but is only honoured after a fixed latency, given as a count of clock cycles. Sector erase marks are loaded by strobe and cleared when the erase finishes or on reset.

Top module: `esr_ctrl`

## Requirements
- R1: A suspend command is a write with data 0xB0 whose address has its top BANK_W bits equal to BANK_ID. The same write with any other bank value has no effect on `susp_req` or `suspended`.
- R2: A suspend command is ignored when `eng_state` is idle (0) or chip erase (3), or while `prog_busy` is high.
- R3: A suspend accepted while `eng_state` is the acceptance window (1) sets `suspended` and `susp_req` on the very edge that samples the command. `resume_cnt` then takes the `eng_progress` value at that edge.
- R4: A suspend accepted while `eng_state` is active erasing (2) raises `susp_req` on the sampling edge. `suspended` rises exactly SUSP_LAT edges later, and `resume_cnt` takes the `eng_progress` value present at that later edge.
- R5: If `eng_state` leaves active erasing (2) while a suspend is pending, the pending request is withdrawn and `suspended` stays low. This holds even on the edge where the latency would expire.
- R6: `mode` encodes 0 = normal, 1 = suspend pending, 2 = erase-suspend-read, 3 = program during suspend. Mode 3 is shown while suspended and `prog_busy` is high, and mode 2 returns when `prog_busy` falls.
- R7: One edge after `rd_addr` is presented, `rd_status` is 1 only if the sector index (top SEC_W address bits) is marked and the erase is live (`eng_state` 1 or 2, or suspended). Otherwise it is 0.
- R8: `pgm_go` pulses one edge after `pgm_req` only while suspended, with `prog_busy` low, the address in this bank, and the addressed sector unmarked.
- R9: A resume (data 0x30, this bank) while suspended and `prog_busy` low clears `suspended` and `susp_req` and pulses `resume_go` for one cycle, with `resume_cnt` holding the saved count. A resume while not suspended, or while `prog_busy` is high, is ignored.
- R10: A suspend written while already suspended or pending changes neither the state nor `resume_cnt`.
- R11: Reset clears `suspended`, `susp_req`, `resume_cnt` and all sector marks. An `erase_done` pulse clears all marks, and wins over a `mark_set` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command data byte |
| cmd_addr | input | ADDR_W | Command address |
| eng_state | input | 2 | Erase engine phase: 0 idle, 1 window, 2 erasing, 3 chip erase |
| eng_progress | input | PROG_W | Erase engine progress count |
| erase_done | input | 1 | Erase complete pulse; clears marks |
| mark_set | input | 1 | Mark the sector of `mark_addr` for erasure |
| mark_addr | input | ADDR_W | Address whose sector is marked |
| prog_busy | input | 1 | A program operation is in progress |
| pgm_req | input | 1 | Program request strobe |
| pgm_addr | input | ADDR_W | Program target address |
| rd_addr | input | ADDR_W | Read address |
| susp_req | output | 1 | Pause request to the erase engine |
| suspended | output | 1 | Erase is suspended |
| resume_go | output | 1 | One-cycle resume pulse to the engine |
| resume_cnt | output | PROG_W | Saved progress count for resuming |
| mode | output | 2 | Mode code as in R6 |
| rd_status | output | 1 | 1 = return status, 0 = return array data |
| pgm_go | output | 1 | Program request granted |

## Verification
The two functions that can meet on one edge are the expiry of the suspend latency and the engine leaving the erasing phase (R5). The bench issues a suspend during erasing and waits SUSP_LAT−1 edges. It then drops `eng_state` to idle so that the engine's change and the latency expiry land on the same edge. After that edge it expects `suspended` and `susp_req` both low. A second pairing, a resume written while a program is still running, is expected to leave the bank suspended.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_WINDOW = 2'd1,
    ENG_ERASE  = 2'd2,
    ENG_CHIP   = 2'd3
  } eng_state_e;

  typedef enum logic [1:0] {
    MODE_NORMAL     = 2'd0,
    MODE_PENDING    = 2'd1,
    MODE_SUSP_READ  = 2'd2,
    MODE_SUSP_PROG  = 2'd3
  } esr_mode_e;

  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;
endpackage

// File: rtl/esr_cmd_dec.sv
module esr_cmd_dec #(
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 2,
  parameter int BANK_ID = 1
) (
  input  logic              cmd_we,
  input  logic [7:0]        cmd_data,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              sus_hit,
  output logic              res_hit
);
  import esr_pkg::*;

  logic [BANK_W-1:0] bank_sel;
  logic              in_bank;

  assign bank_sel = cmd_addr[ADDR_W-1 -: BANK_W];
  assign in_bank  = (bank_sel == BANK_W'(BANK_ID));
  assign sus_hit  = cmd_we && in_bank && (cmd_data == CMD_SUSPEND);
  assign res_hit  = cmd_we && in_bank && (cmd_data == CMD_RESUME);
endmodule

// File: rtl/esr_susp_fsm.sv
module esr_susp_fsm #(
  parameter int PROG_W   = 16,
  parameter int SUSP_LAT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sus_hit,
  input  logic              res_hit,
  input  logic [1:0]        eng_state,
  input  logic [PROG_W-1:0] eng_progress,
  input  logic              prog_busy,
  output logic              susp_q,
  output logic              pend_q,
  output logic              res_go_q,
  output logic [PROG_W-1:0] saved_q
);
  import esr_pkg::*;

  localparam int CNT_W = (SUSP_LAT < 2) ? 1 : $clog2(SUSP_LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUSP_LAT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      susp_q   <= 1'b0;
      pend_q   <= 1'b0;
      res_go_q <= 1'b0;
      cnt_q    <= '0;
      saved_q  <= '0;
    end else begin
      res_go_q <= 1'b0;
      if (susp_q) begin
        if (res_hit && !prog_busy) begin
          susp_q   <= 1'b0;
          res_go_q <= 1'b1;
        end
      end else if (pend_q) begin
        if (eng_state != ENG_ERASE) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else if (cnt_q == CNT_LAST) begin
          pend_q  <= 1'b0;
          susp_q  <= 1'b1;
          saved_q <= eng_progress;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (sus_hit && !prog_busy) begin
        if (eng_state == ENG_WINDOW) begin
          susp_q  <= 1'b1;
          saved_q <= eng_progress;
        end else if (eng_state == ENG_ERASE) begin
          pend_q <= 1'b1;
          cnt_q  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/esr_sector_map.sv
module esr_sector_map #(
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 2,
  parameter int SEC_W   = 6,
  parameter int BANK_ID = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_done,
  input  logic              mark_set,
  input  logic [ADDR_W-1:0] mark_addr,
  input  logic              erase_live,
  input  logic              suspended,
  input  logic              prog_busy,
  input  logic              pgm_req,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_status,
  output logic              pgm_go
);
  localparam int NSEC = 1 << SEC_W;

  logic [NSEC-1:0]   mark_q;
  logic [SEC_W-1:0]  mark_idx;
  logic [SEC_W-1:0]  rd_idx;
  logic [SEC_W-1:0]  pgm_idx;
  logic              pgm_in_bank;

  assign mark_idx    = mark_addr[ADDR_W-1 -: SEC_W];
  assign rd_idx      = rd_addr[ADDR_W-1 -: SEC_W];
  assign pgm_idx     = pgm_addr[ADDR_W-1 -: SEC_W];
  assign pgm_in_bank = (pgm_addr[ADDR_W-1 -: BANK_W] == BANK_W'(BANK_ID));

  for (genvar s = 0; s < NSEC; s++) begin : g_mark
    always_ff @(posedge clk) begin
      if (rst || erase_done) begin
        mark_q[s] <= 1'b0;
      end else if (mark_set && (mark_idx == SEC_W'(s))) begin
        mark_q[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_status <= 1'b0;
      pgm_go    <= 1'b0;
    end else begin
      rd_status <= erase_live && mark_q[rd_idx];
      pgm_go    <= pgm_req && suspended && !prog_busy && pgm_in_bank
                   && !mark_q[pgm_idx];
    end
  end
endmodule

// File: rtl/esr_ctrl.sv
module esr_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 2,
  parameter int SEC_W    = 6,
  parameter int BANK_ID  = 1,
  parameter int PROG_W   = 16,
  parameter int SUSP_LAT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_data,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        eng_state,
  input  logic [PROG_W-1:0] eng_progress,
  input  logic              erase_done,
  input  logic              mark_set,
  input  logic [ADDR_W-1:0] mark_addr,
  input  logic              prog_busy,
  input  logic              pgm_req,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              susp_req,
  output logic              suspended,
  output logic              resume_go,
  output logic [PROG_W-1:0] resume_cnt,
  output logic [1:0]        mode,
  output logic              rd_status,
  output logic              pgm_go
);
  import esr_pkg::*;

  logic sus_hit, res_hit;
  logic susp_q, pend_q;
  logic erase_live;
  esr_mode_e mode_w;

  esr_cmd_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_ID(BANK_ID)) u_dec (
    .cmd_we  (cmd_we),
    .cmd_data(cmd_data),
    .cmd_addr(cmd_addr),
    .sus_hit (sus_hit),
    .res_hit (res_hit)
  );

  esr_susp_fsm #(.PROG_W(PROG_W), .SUSP_LAT(SUSP_LAT)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sus_hit     (sus_hit),
    .res_hit     (res_hit),
    .eng_state   (eng_state),
    .eng_progress(eng_progress),
    .prog_busy   (prog_busy),
    .susp_q      (susp_q),
    .pend_q      (pend_q),
    .res_go_q    (resume_go),
    .saved_q     (resume_cnt)
  );

  assign erase_live = (eng_state == ENG_WINDOW) || (eng_state == ENG_ERASE) || susp_q;

  esr_sector_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SEC_W(SEC_W), .BANK_ID(BANK_ID)) u_map (
    .clk       (clk),
    .rst       (rst),
    .erase_done(erase_done),
    .mark_set  (mark_set),
    .mark_addr (mark_addr),
    .erase_live(erase_live),
    .suspended (susp_q),
    .prog_busy (prog_busy),
    .pgm_req   (pgm_req),
    .pgm_addr  (pgm_addr),
    .rd_addr   (rd_addr),
    .rd_status (rd_status),
    .pgm_go    (pgm_go)
  );

  always_comb begin
    if (susp_q)      mode_w = prog_busy ? MODE_SUSP_PROG : MODE_SUSP_READ;
    else if (pend_q) mode_w = MODE_PENDING;
    else             mode_w = MODE_NORMAL;
  end

  assign mode      = mode_w;
  assign suspended = susp_q;
  assign susp_req  = susp_q || pend_q;
endmodule

// File: rtl/esr_ctrl_chk.sv
module esr_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 2,
  parameter int SEC_W    = 6,
  parameter int BANK_ID  = 1,
  parameter int PROG_W   = 16,
  parameter int SUSP_LAT = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_we,
  input logic [7:0]        cmd_data,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [1:0]        eng_state,
  input logic              prog_busy,
  input logic              susp_req,
  input logic              suspended,
  input logic              resume_go,
  input logic [PROG_W-1:0] resume_cnt,
  input logic              rd_status,
  input logic              pgm_go
);
  localparam int WAIT_W = $clog2(SUSP_LAT + 2);

  logic bank_ok, sus_cmd, res_cmd, waiting;
  logic [WAIT_W-1:0] wait_cnt;

  assign bank_ok = (cmd_addr[ADDR_W-1 -: BANK_W] == BANK_W'(BANK_ID));
  assign sus_cmd = cmd_we && bank_ok && (cmd_data == 8'hB0);
  assign res_cmd = cmd_we && bank_ok && (cmd_data == 8'h30);
  assign waiting = susp_req && !suspended;

  always_ff @(posedge clk) begin
    if (rst || !waiting) wait_cnt <= '0;
    else                 wait_cnt <= wait_cnt + 1'b1;
  end

  assert_window_at_once_R3: assert property (@(posedge clk) disable iff (rst)
    (sus_cmd && eng_state == 2'd1 && !susp_req && !prog_busy) |=> suspended);

  assert_ignored_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (sus_cmd && (eng_state == 2'd0 || eng_state == 2'd3) && !susp_req) |=> !susp_req);

  assert_latency_bound_R4: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (wait_cnt < WAIT_W'(SUSP_LAT)));

  assert_resume_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (suspended && res_cmd && !prog_busy) |=> (!suspended && resume_go));

  assert_resume_only_after_susp_R9: assert property (@(posedge clk) disable iff (rst)
    resume_go |-> $past(suspended));

  assert_grant_only_suspended_R8: assert property (@(posedge clk) disable iff (rst)
    pgm_go |-> $past(suspended));

  assert_second_suspend_R10: assert property (@(posedge clk) disable iff (rst)
    (suspended && sus_cmd) |=> (suspended && $stable(resume_cnt)));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!suspended && !susp_req && !rd_status && !pgm_go));
endmodule

bind esr_ctrl esr_ctrl_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .SEC_W(SEC_W),
  .BANK_ID(BANK_ID), .PROG_W(PROG_W), .SUSP_LAT(SUSP_LAT)
) u_chk (.*);

// File: tb/esr_ctrl_test.sv
module esr_ctrl_test;
  localparam int AW  = 16;
  localparam int PW  = 16;
  localparam int LAT = 40;
  localparam logic [AW-1:0] SEC17 = 16'h4400;
  localparam logic [AW-1:0] SEC18 = 16'h4800;
  localparam logic [AW-1:0] OTHER = 16'h8000;

  logic clk = 1'b0;
  logic rst;
  logic cmd_we, erase_done, mark_set, prog_busy, pgm_req;
  logic [7:0] cmd_data;
  logic [AW-1:0] cmd_addr, mark_addr, pgm_addr, rd_addr;
  logic [1:0] eng_state;
  logic [PW-1:0] eng_progress;
  logic susp_req, suspended, resume_go, rd_status, pgm_go;
  logic [PW-1:0] resume_cnt;
  logic [1:0] mode;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  esr_ctrl #(.ADDR_W(AW), .PROG_W(PW), .SUSP_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
    .eng_state(eng_state), .eng_progress(eng_progress), .erase_done(erase_done),
    .mark_set(mark_set), .mark_addr(mark_addr), .prog_busy(prog_busy),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .rd_addr(rd_addr),
    .susp_req(susp_req), .suspended(suspended), .resume_go(resume_go),
    .resume_cnt(resume_cnt), .mode(mode), .rd_status(rd_status), .pgm_go(pgm_go)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_we = 1'b0; cmd_data = '0; cmd_addr = '0; eng_state = 2'd0;
    eng_progress = '0; erase_done = 1'b0; mark_set = 1'b0; mark_addr = '0;
    prog_busy = 1'b0; pgm_req = 1'b0; pgm_addr = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
    cmd_we = 1'b1; cmd_data = d; cmd_addr = a;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic mark(input logic [AW-1:0] a);
    mark_set = 1'b1; mark_addr = a;
    @(negedge clk);
    mark_set = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic exp, input string req);
    rd_addr = a;
    @(negedge clk);
    check(req, rd_status, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 reset suspended", suspended, 0);
    check("R11 reset susp_req", susp_req, 0);
    check("R11 reset resume_cnt", resume_cnt, 0);
    check("R6 reset mode", mode, 0);
  endtask

  task automatic t_window();
    do_reset();
    eng_state = 2'd1; eng_progress = 16'd37;
    mark(SEC17);
    wr(8'hB0, SEC18);
    check("R3 window suspend at once", suspended, 1);
    check("R6 mode susp read", mode, 2);
    rd(SEC17, 1'b1, "R7 marked sector status");
    rd(SEC18, 1'b0, "R7 unmarked sector data");
    eng_progress = 16'd50;
    wr(8'hB0, SEC17);
    check("R10 second suspend keeps state", suspended, 1);
    wr(8'h30, SEC17);
    check("R9 resume clears", suspended, 0);
    check("R9 resume pulse", resume_go, 1);
    check("R10 R9 saved count", resume_cnt, 37);
    @(negedge clk);
    check("R9 resume pulse one cycle", resume_go, 0);
  endtask

  task automatic t_active();
    do_reset();
    eng_state = 2'd2; eng_progress = 16'd100;
    mark(SEC17);
    rd(SEC17, 1'b1, "R7 status while erasing");
    wr(8'hB0, SEC17);
    check("R4 request raised", susp_req, 1);
    check("R4 not yet suspended", suspended, 0);
    check("R6 mode pending", mode, 1);
    repeat (LAT - 1) @(negedge clk);
    check("R4 still pending one edge early", suspended, 0);
    eng_progress = 16'd105;
    @(negedge clk);
    check("R4 suspended after latency", suspended, 1);
    wr(8'h30, OTHER);
    check("R1 resume other bank ignored", suspended, 1);
    wr(8'h30, SEC18);
    check("R4 saved progress", resume_cnt, 105);
    check("R9 resumed", susp_req, 0);
    erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    rd(SEC17, 1'b0, "R11 erase_done clears marks");
  endtask

  task automatic t_ignored();
    do_reset();
    eng_state = 2'd2;
    wr(8'hB0, OTHER);
    check("R1 other bank ignored", susp_req, 0);
    eng_state = 2'd3;
    wr(8'hB0, SEC17);
    check("R2 chip erase ignored", susp_req, 0);
    eng_state = 2'd0;
    wr(8'hB0, SEC17);
    check("R2 idle ignored", susp_req, 0);
    eng_state = 2'd2; prog_busy = 1'b1;
    wr(8'hB0, SEC17);
    check("R2 program busy ignored", susp_req, 0);
    prog_busy = 1'b0;
    wr(8'h30, SEC17);
    check("R9 resume when not suspended", resume_go, 0);
  endtask

  task automatic t_withdraw();
    do_reset();
    eng_state = 2'd2;
    wr(8'hB0, SEC17);
    repeat (LAT - 1) @(negedge clk);
    eng_state = 2'd0;
    @(negedge clk);
    check("R5 withdrawn on expiry edge", suspended, 0);
    check("R5 request dropped", susp_req, 0);
  endtask

  task automatic t_program();
    do_reset();
    eng_state = 2'd1; eng_progress = 16'd9;
    mark(SEC17);
    pgm_req = 1'b1; pgm_addr = SEC18;
    @(negedge clk); pgm_req = 1'b0;
    check("R8 no grant when not suspended", pgm_go, 0);
    wr(8'hB0, SEC17);
    pgm_req = 1'b1; pgm_addr = SEC18;
    @(negedge clk); pgm_req = 1'b0;
    check("R8 grant unmarked sector", pgm_go, 1);
    pgm_req = 1'b1; pgm_addr = SEC17;
    @(negedge clk); pgm_req = 1'b0;
    check("R8 deny marked sector", pgm_go, 0);
    prog_busy = 1'b1;
    #1 check("R6 mode program in suspend", mode, 3);
    wr(8'h30, SEC17);
    check("R9 resume ignored while programming", suspended, 1);
    prog_busy = 1'b0;
    #1 check("R6 back to susp read", mode, 2);
    do_reset();
    eng_state = 2'd1;
    rd(SEC17, 1'b0, "R11 reset clears marks");
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_window();
    t_active();
    t_ignored();
    t_withdraw();
    t_program();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule